// File: doc/BRIEF.md
# Lockable Extended Register Bank

This block holds six extended graphics-controller registers behind a small synchronous index/data port. A host drives an 8-bit index with a write strobe or a read strobe. Writes land on the clock edge that samples the strobe. Reads return data on the port one clock later. Index 0x0F is a key register and can always be reached. Writing a key whose low three bits equal 5 raises an unlock flag. Any other key value drops the flag.

The guarded registers sit at indices 0x09 to 0x0E: a two-byte address offset at 0x09 and 0x0A, then memory size, video select, CRTC lock and video control. Bit 1 of video control is a compatibility bit. The unlock flag and the inverted compatibility bit together form a two-bit access mode.

| Mode | Guarded reads | Guarded writes |
|------|---------------|----------------|
| 0 | return 0xFF | ignored |
| 1 | allowed | allowed |
| 2 | return 0xFF | allowed |
| 3 | allowed | allowed |

The mode is exported so that logic around the block can follow it. Bits 0 and 1 of video control are also exported as an 8-bit RGB enable and a compatibility flag.

Top module: `xreg_bank`

## Requirements
- R1: After synchronous reset, all six guarded registers read 0x00, the key register reads 0x00, `rdata` is 0x00, `rgb8_en` and `compat_en` are 0, and `mode` is 1.
- R2: A write to index 0x0F sets the unlock flag (`mode` bit 1) when `wdata[2:0]` equals 5, and clears it for any other value. The upper data bits play no part.
- R3: A read of index 0x0F returns the unlock flag in bit 0 and the low three bits of the last key written in bits 3:1. Bits 7:4 read 0.
- R4: Bit 0 of the register at index 0x0E drives `rgb8_en`, and bit 1 drives `compat_en`.
- R5: `mode` equals {unlock flag, NOT compatibility bit}. It changes only on the edge of a write to index 0x0E or 0x0F, and it shows the new value right after that edge.
- R6: In mode 0, reads of indices 0x09–0x0E return 0xFF, and writes to them change nothing. This includes writes to 0x0E, so the mode cannot leave 0 through that register.
- R7: In modes 1 and 3, each guarded index returns what was last written to it.
- R8: In mode 2, reads of indices 0x09–0x0E return 0xFF, but writes to them are stored and can be read back once the mode allows reads.
- R9: Reads of indices outside 0x09–0x0F return 0x00, and writes to them change no register.
- R10: `rdata` changes only on the clock edge that samples `rd_en` high. It holds its value at all other times.
- R11: The six guarded indices are independent 8-bit registers. A write to one leaves the other five unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed index |
| rd_en | input | 1 | Read strobe for the addressed index |
| idx | input | 8 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rgb8_en | output | 1 | Video control bit 0 |
| compat_en | output | 1 | Video control bit 1 (compatibility bit) |
| mode | output | 2 | Current access mode {unlock, ~compat} |

## Verification
The bench builds the block with its default parameters:
- 8-bit index and data
- six guarded slots starting at 0x09, so video control is at 0x0E and the key is at 0x0F
- a 3-bit key that matches the value 5

With these values all four access modes can be reached from the port. Reaching them takes a short, fixed sequence of key writes and video-control writes. The bench walks every mode transition, including the escape from mode 0 through mode 2. It also confirms that writes accepted blind in mode 2, or ignored in mode 0, show up correctly once full access returns.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

    localparam int DATA_W     = 8;
    localparam int IDX_W      = 8;
    localparam int GUARD_BASE = 9;
    localparam int NUM_GUARD  = 6;
    localparam int KEY_W      = 3;
    localparam int KEY_VAL    = 5;

    typedef enum logic [1:0] {
        MODE_SEALED = 2'd0,
        MODE_PLAIN  = 2'd1,
        MODE_BLIND  = 2'd2,
        MODE_FULL   = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic compat;
        logic rgb8;
    } vctl_t;

    function automatic logic mode_can_read(acc_mode_e m);
        return (m == MODE_PLAIN) || (m == MODE_FULL);
    endfunction

    function automatic logic mode_can_write(acc_mode_e m);
        return m != MODE_SEALED;
    endfunction

    function automatic acc_mode_e mode_of(logic unlock, logic compat);
        return acc_mode_e'({unlock, ~compat});
    endfunction

endpackage

// File: rtl/xreg_key_unit.sv
module xreg_key_unit #(
    parameter int KEY_W   = xreg_pkg::KEY_W,
    parameter int KEY_VAL = xreg_pkg::KEY_VAL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_in,
    output logic             unlock_q,
    output logic             unlock_d,
    output logic [KEY_W-1:0] key_q
);

    always_comb begin
        unlock_d = unlock_q;
        if (key_we) begin
            unlock_d = (key_in == KEY_W'(KEY_VAL));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= 1'b0;
            key_q    <= '0;
        end else if (key_we) begin
            unlock_q <= unlock_d;
            key_q    <= key_in;
        end
    end

endmodule

// File: rtl/xreg_guard_file.sv
module xreg_guard_file #(
    parameter int DATA_W    = xreg_pkg::DATA_W,
    parameter int NUM_GUARD = xreg_pkg::NUM_GUARD,
    localparam int SLOT_W   = (NUM_GUARD > 1) ? $clog2(NUM_GUARD) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [SLOT_W-1:0]                 slot,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_GUARD-1:0][DATA_W-1:0]  regs_q
);

    for (genvar g = 0; g < NUM_GUARD; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (we && (slot == SLOT_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/xreg_mode_ctl.sv
module xreg_mode_ctl
    import xreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      key_we,
    input  logic      vctl_we,
    input  logic      unlock_d,
    input  logic      compat_d,
    output acc_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PLAIN;
        end else if (key_we || vctl_we) begin
            mode_q <= mode_of(unlock_d, compat_d);
        end
    end

endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
    import xreg_pkg::*;
#(
    parameter int DATA_W     = xreg_pkg::DATA_W,
    parameter int IDX_W      = xreg_pkg::IDX_W,
    parameter int GUARD_BASE = xreg_pkg::GUARD_BASE,
    parameter int NUM_GUARD  = xreg_pkg::NUM_GUARD,
    parameter int KEY_W      = xreg_pkg::KEY_W,
    parameter int KEY_VAL    = xreg_pkg::KEY_VAL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rgb8_en,
    output logic              compat_en,
    output logic [1:0]        mode
);

    localparam int GUARD_LAST = GUARD_BASE + NUM_GUARD - 1;
    localparam int VCTL_IDX   = GUARD_LAST;
    localparam int KEY_IDX    = GUARD_LAST + 1;
    localparam int SLOT_W     = (NUM_GUARD > 1) ? $clog2(NUM_GUARD) : 1;
    localparam int PAD_W      = DATA_W - KEY_W - 1;

    logic                             in_guard;
    logic                             is_key;
    logic [SLOT_W-1:0]                slot;
    logic                             g_we;
    logic                             key_we;
    logic                             vctl_we;
    logic                             unlock_q;
    logic                             unlock_d;
    logic                             compat_d;
    logic [KEY_W-1:0]                 key_q;
    logic [NUM_GUARD-1:0][DATA_W-1:0] regs_q;
    acc_mode_e                        mode_q;
    vctl_t                            vctl;
    logic [DATA_W-1:0]                rd_next;

    // index decode
    assign in_guard = (idx >= IDX_W'(GUARD_BASE)) && (idx <= IDX_W'(GUARD_LAST));
    assign is_key   = (idx == IDX_W'(KEY_IDX));
    assign slot     = SLOT_W'(idx - IDX_W'(GUARD_BASE));

    assign g_we    = wr_en && in_guard && mode_can_write(mode_q);
    assign key_we  = wr_en && is_key;
    assign vctl_we = g_we && (idx == IDX_W'(VCTL_IDX));

    xreg_key_unit #(
        .KEY_W   (KEY_W),
        .KEY_VAL (KEY_VAL)
    ) u_key (
        .clk      (clk),
        .rst      (rst),
        .key_we   (key_we),
        .key_in   (wdata[KEY_W-1:0]),
        .unlock_q (unlock_q),
        .unlock_d (unlock_d),
        .key_q    (key_q)
    );

    xreg_guard_file #(
        .DATA_W    (DATA_W),
        .NUM_GUARD (NUM_GUARD)
    ) u_file (
        .clk    (clk),
        .rst    (rst),
        .we     (g_we),
        .slot   (slot),
        .wdata  (wdata),
        .regs_q (regs_q)
    );

    assign vctl     = vctl_t'(regs_q[NUM_GUARD-1][1:0]);
    assign compat_d = vctl_we ? wdata[1] : vctl.compat;

    xreg_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .key_we   (key_we),
        .vctl_we  (vctl_we),
        .unlock_d (unlock_d),
        .compat_d (compat_d),
        .mode_q   (mode_q)
    );

    // read path, registered
    always_comb begin
        rd_next = '0;
        if (in_guard) begin
            rd_next = mode_can_read(mode_q) ? regs_q[slot] : '1;
        end else if (is_key) begin
            rd_next = {{PAD_W{1'b0}}, key_q, unlock_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

    assign rgb8_en   = vctl.rgb8;
    assign compat_en = vctl.compat;
    assign mode      = mode_q;

endmodule

// File: rtl/xreg_bank_chk.sv
module xreg_bank_chk #(
    parameter int DATA_W     = xreg_pkg::DATA_W,
    parameter int IDX_W      = xreg_pkg::IDX_W,
    parameter int GUARD_BASE = xreg_pkg::GUARD_BASE,
    parameter int NUM_GUARD  = xreg_pkg::NUM_GUARD,
    parameter int KEY_W      = xreg_pkg::KEY_W,
    parameter int KEY_VAL    = xreg_pkg::KEY_VAL
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [IDX_W-1:0]  idx,
    input logic [KEY_W-1:0]  key_bits,
    input logic [DATA_W-1:0] rdata,
    input logic              rgb8_en,
    input logic              compat_en,
    input logic [1:0]        mode
);

    localparam int GUARD_LAST = GUARD_BASE + NUM_GUARD - 1;
    localparam int KEY_IDX    = GUARD_LAST + 1;

    logic guard_hit;
    logic key_hit;
    logic vctl_hit;
    assign guard_hit = (idx >= IDX_W'(GUARD_BASE)) && (idx <= IDX_W'(GUARD_LAST));
    assign key_hit   = (idx == IDX_W'(KEY_IDX));
    assign vctl_hit  = (idx == IDX_W'(GUARD_LAST));

    // R6 R8
    guard_read_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && guard_hit && !mode[0]) |=> (rdata == '1));

    // R2
    key_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && key_hit && (key_bits == KEY_W'(KEY_VAL))) |=> mode[1]);

    // R2
    key_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && key_hit && (key_bits != KEY_W'(KEY_VAL))) |=> !mode[1]);

    // R9
    outside_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !guard_hit && !key_hit) |=> (rdata == '0));

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (vctl_hit || key_hit)) |=> $stable(mode));

    // R5 R4
    mode_compat_chk: assert property (@(posedge clk) disable iff (rst)
        mode[0] != compat_en);

    // R6
    sealed_vctl_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && vctl_hit && (mode == 2'd0)) |=> ($stable({rgb8_en, compat_en}) && (mode == 2'd0)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

bind xreg_bank xreg_bank_chk #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .GUARD_BASE (GUARD_BASE),
    .NUM_GUARD  (NUM_GUARD),
    .KEY_W      (KEY_W),
    .KEY_VAL    (KEY_VAL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .idx       (idx),
    .key_bits  (wdata[KEY_W-1:0]),
    .rdata     (rdata),
    .rgb8_en   (rgb8_en),
    .compat_en (compat_en),
    .mode      (mode)
);

// File: tb/xreg_bank_test.sv
`timescale 1ns/1ps
module xreg_bank_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] idx = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rgb8_en;
    logic       compat_en;
    logic [1:0] mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xreg_bank uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .idx       (idx),
        .wdata     (wdata),
        .rdata     (rdata),
        .rgb8_en   (rgb8_en),
        .compat_en (compat_en),
        .mode      (mode)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] ix;
        logic [7:0] wd;
        logic [7:0] exp_rd;
        logic [1:0] exp_md;
        logic       exp_rgb;
        logic       exp_cmp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 8'h0E, 8'h00, 8'h00, 2'd1, 1'b0, 1'b0, 8'd1},  // R1
        '{1'b0, 1'b1, 8'h0F, 8'h00, 8'h00, 2'd1, 1'b0, 1'b0, 8'd1},  // R1
        '{1'b1, 1'b0, 8'h09, 8'hAA, 8'h00, 2'd1, 1'b0, 1'b0, 8'd7},  // R7
        '{1'b1, 1'b0, 8'h0A, 8'h55, 8'h00, 2'd1, 1'b0, 1'b0, 8'd7},
        '{1'b1, 1'b0, 8'h0B, 8'h3C, 8'h00, 2'd1, 1'b0, 1'b0, 8'd7},
        '{1'b1, 1'b0, 8'h0C, 8'hC3, 8'h00, 2'd1, 1'b0, 1'b0, 8'd7},
        '{1'b1, 1'b0, 8'h0D, 8'h81, 8'h00, 2'd1, 1'b0, 1'b0, 8'd7},
        '{1'b0, 1'b1, 8'h09, 8'h00, 8'hAA, 2'd1, 1'b0, 1'b0, 8'd11}, // R11
        '{1'b0, 1'b1, 8'h0A, 8'h00, 8'h55, 2'd1, 1'b0, 1'b0, 8'd11},
        '{1'b0, 1'b1, 8'h0B, 8'h00, 8'h3C, 2'd1, 1'b0, 1'b0, 8'd11},
        '{1'b0, 1'b1, 8'h0C, 8'h00, 8'hC3, 2'd1, 1'b0, 1'b0, 8'd11},
        '{1'b0, 1'b1, 8'h0D, 8'h00, 8'h81, 2'd1, 1'b0, 1'b0, 8'd11},
        '{1'b1, 1'b0, 8'h0E, 8'h01, 8'h00, 2'd1, 1'b1, 1'b0, 8'd4},  // R4
        '{1'b0, 1'b1, 8'h0E, 8'h00, 8'h01, 2'd1, 1'b1, 1'b0, 8'd7},
        '{1'b1, 1'b0, 8'h0E, 8'h03, 8'h00, 2'd0, 1'b1, 1'b1, 8'd5},  // R5
        '{1'b0, 1'b1, 8'h09, 8'h00, 8'hFF, 2'd0, 1'b1, 1'b1, 8'd6},  // R6
        '{1'b1, 1'b0, 8'h09, 8'h11, 8'h00, 2'd0, 1'b1, 1'b1, 8'd6},
        '{1'b1, 1'b0, 8'h0E, 8'h00, 8'h00, 2'd0, 1'b1, 1'b1, 8'd6},
        '{1'b1, 1'b0, 8'h0F, 8'h0D, 8'h00, 2'd2, 1'b1, 1'b1, 8'd2},  // R2
        '{1'b0, 1'b1, 8'h0F, 8'h00, 8'h0B, 2'd2, 1'b1, 1'b1, 8'd3},  // R3
        '{1'b0, 1'b1, 8'h09, 8'h00, 8'hFF, 2'd2, 1'b1, 1'b1, 8'd8},  // R8
        '{1'b1, 1'b0, 8'h0C, 8'h77, 8'h00, 2'd2, 1'b1, 1'b1, 8'd8},
        '{1'b1, 1'b0, 8'h0E, 8'h01, 8'h00, 2'd3, 1'b1, 1'b0, 8'd8},
        '{1'b0, 1'b1, 8'h09, 8'h00, 8'hAA, 2'd3, 1'b1, 1'b0, 8'd6},
        '{1'b0, 1'b1, 8'h0C, 8'h00, 8'h77, 2'd3, 1'b1, 1'b0, 8'd8},
        '{1'b0, 1'b1, 8'h0E, 8'h00, 8'h01, 2'd3, 1'b1, 1'b0, 8'd7},
        '{1'b1, 1'b0, 8'h0F, 8'h04, 8'h00, 2'd1, 1'b1, 1'b0, 8'd2},
        '{1'b0, 1'b1, 8'h0F, 8'h00, 8'h08, 2'd1, 1'b1, 1'b0, 8'd3},
        '{1'b0, 1'b1, 8'h08, 8'h00, 8'h00, 2'd1, 1'b1, 1'b0, 8'd9},  // R9
        '{1'b0, 1'b1, 8'h10, 8'h00, 8'h00, 2'd1, 1'b1, 1'b0, 8'd9},
        '{1'b1, 1'b0, 8'h10, 8'hFF, 8'h00, 2'd1, 1'b1, 1'b0, 8'd9},
        '{1'b0, 1'b1, 8'h0F, 8'h00, 8'h08, 2'd1, 1'b1, 1'b0, 8'd9},
        '{1'b1, 1'b0, 8'h0F, 8'hF5, 8'h00, 2'd3, 1'b1, 1'b0, 8'd2},
        '{1'b0, 1'b1, 8'h0F, 8'h00, 8'h0B, 2'd3, 1'b1, 1'b0, 8'd3}
    };

    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [7:0] ix, input logic [7:0] wd);
        @(negedge clk);
        wr_en = w;
        rd_en = r;
        idx   = ix;
        wdata = wd;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic check_reset_state();
        // R1
        chk(1, "rdata", rdata, 8'h00);
        chk(1, "mode", {6'd0, mode}, 8'd1);
        chk(1, "rgb8_en", {7'd0, rgb8_en}, 8'd0);
        chk(1, "compat_en", {7'd0, compat_en}, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        for (int i = 0; i < NV; i++) begin
            op(VEC[i].wr, VEC[i].rd, VEC[i].ix, VEC[i].wd);
            if (VEC[i].rd) chk(int'(VEC[i].req), "rdata", rdata, VEC[i].exp_rd);
            chk(int'(VEC[i].req), "mode", {6'd0, mode}, {6'd0, VEC[i].exp_md});
            chk(4, "rgb8_en", {7'd0, rgb8_en}, {7'd0, VEC[i].exp_rgb});
            chk(4, "compat_en", {7'd0, compat_en}, {7'd0, VEC[i].exp_cmp});
        end

        // R10: read data moves only at the sampling edge, then holds
        op(1'b0, 1'b1, 8'h0C, 8'h00);
        chk(10, "rdata", rdata, 8'h77);
        @(negedge clk);
        rd_en = 1'b1;
        idx   = 8'h09;
        #5;
        chk(10, "rdata before edge", rdata, 8'h77);
        @(negedge clk);
        rd_en = 1'b0;
        chk(10, "rdata after edge", rdata, 8'hAA);
        idx = 8'h0A;
        repeat (2) @(negedge clk);
        chk(10, "rdata held", rdata, 8'hAA);

        // R11: neighbour slots untouched by the blind write in mode 2
        op(1'b0, 1'b1, 8'h0B, 8'h00);
        chk(11, "rdata", rdata, 8'h3C);
        op(1'b0, 1'b1, 8'h0D, 8'h00);
        chk(11, "rdata", rdata, 8'h81);

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_reset_state();
        op(1'b0, 1'b1, 8'h0C, 8'h00);
        chk(1, "guard after reset", rdata, 8'h00);
        op(1'b0, 1'b1, 8'h0F, 8'h00);
        chk(1, "key after reset", rdata, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule